// File: doc/BRIEF.md
# Dual Serial Channel Register Front End

This block is the register-facing side of a two-channel serial controller. A host reaches it through a simple strobed bus: a 4-bit address, separate read and write strobes and 8-bit data. Behind that bus it holds three mode registers for each channel, an interrupt mask, and a general-purpose scratch byte. Each channel also has a command register. The block carries out a small set of commands written to the upper nibble of that register. Its outputs are the stored mode bytes, fields decoded from them, and the control levels the commands set: an active-low request-to-send line and a time-out enable for each channel, and one power-down level.

The three mode registers of a channel sit behind a single address. A per-channel pointer picks which one a read or write reaches. The pointer advances on every access to that address and stops at the last register. A command moves it back to the first. Reading the interrupt address returns the external status byte ANDed bit by bit with the mask. The mask itself can only be written. Read data is combinational while the read strobe is high and is zero otherwise. The bus has no flow control: every strobe completes in the cycle it is given, so there is no back-pressure.

Top module: `sercfg_front`

## Requirements
- R1: After reset, rts_n_a and rts_n_b are 1, both time-out enables are 0, pdown is 0, all mode registers, the mask and the scratch byte are 0, and both mode pointers select mode register 1.
- R2: Each read or write at a channel's mode address (0x0 for A, 0x8 for B) reaches the selected register, then steps the pointer from register 0 to 1 to 2. Once on register 2, the pointer stays there.
- R3: Command 0xB (binary 1011) in the upper nibble of a command write (0x2 for A, 0xA for B) points that channel's mode pointer at register 0. The other channel's pointer is unchanged.
- R4: Command 0x8 drives the channel's rts_n output to 0, and command 0x9 drives it to 1. Each channel is independent.
- R5: Command 0xA sets the channel's time-out enable, and command 0xC clears it.
- R6: Command 0xE sets pdown and command 0xF clears it, but only when written to channel A's command address. Channel B writes of these codes leave pdown unchanged.
- R7: Commands 0xD and 0x0 change no output. The lower nibble of a command write is ignored.
- R8: A read at 0x2 returns irq_status AND the mask. Writing 0x5 loads the mask, and reading 0x5 returns irq_status unmasked.
- R9: Address 0xC is a read/write scratch byte.
- R10: Bits 2:1 of channel B's mode register 0 are never stored and always read as 0. Bits 2:1 of channel A's mode register 0 appear on ext_baud_a.
- R11: wdog_en is bit 7 of the channel's mode register 0, tx_lvl is its bits 5:4, and rx_lvl is {mode register 0 bit 6, mode register 1 bit 6}.
- R12: rdata is 0 while rd_en is low, and also on reads of unmapped addresses.
- R13: Accesses to addresses other than a channel's mode address do not move that channel's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when rd_en is low |
| irq_status | input | 8 | Interrupt source levels |
| rts_n_a | output | 1 | Channel A request-to-send, active low |
| rts_n_b | output | 1 | Channel B request-to-send, active low |
| tmo_en_a | output | 1 | Channel A time-out enable |
| tmo_en_b | output | 1 | Channel B time-out enable |
| pdown | output | 1 | Power-down request |
| mr0_a | output | 8 | Channel A mode register 0 |
| mr1_a | output | 8 | Channel A mode register 1 |
| mr2_a | output | 8 | Channel A mode register 2 |
| mr0_b | output | 8 | Channel B mode register 0 |
| mr1_b | output | 8 | Channel B mode register 1 |
| mr2_b | output | 8 | Channel B mode register 2 |
| wdog_en_a | output | 1 | Channel A watchdog enable |
| wdog_en_b | output | 1 | Channel B watchdog enable |
| rx_lvl_a | output | 2 | Channel A receive threshold code |
| rx_lvl_b | output | 2 | Channel B receive threshold code |
| tx_lvl_a | output | 2 | Channel A transmit threshold code |
| tx_lvl_b | output | 2 | Channel B transmit threshold code |
| ext_baud_a | output | 2 | Channel A extended rate table select |

## Verification
A mask write and a change of the external status input can land in the same clock cycle. The bench provokes this by driving a new irq_status value in the very cycle it writes 0x5. A masked read in the next cycle must equal the new status ANDed with the new mask, and a raw read at 0x5 must show the new status alone. A second overlap is a pointer-reset command following accesses that left the pointer at its end stop. The next mode write must land in register 0, which the bench judges from the register outputs.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NCH    = 2;
  localparam int CMD_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_MODE_A  = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_CMD_A   = 4'h2; // write: command A, read: masked status
  localparam logic [ADDR_W-1:0] ADR_STATMSK = 4'h5; // write: mask, read: raw status
  localparam logic [ADDR_W-1:0] ADR_MODE_B  = 4'h8;
  localparam logic [ADDR_W-1:0] ADR_CMD_B   = 4'hA;
  localparam logic [ADDR_W-1:0] ADR_SCRATCH = 4'hC;

  typedef enum logic [1:0] {
    MP_MR0 = 2'd0,
    MP_MR1 = 2'd1,
    MP_MR2 = 2'd2
  } mode_ptr_e;

  localparam logic [CMD_W-1:0] CMD_RTS_ON  = 4'b1000;
  localparam logic [CMD_W-1:0] CMD_RTS_OFF = 4'b1001;
  localparam logic [CMD_W-1:0] CMD_TMO_ON  = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_PTR_MR0 = 4'b1011;
  localparam logic [CMD_W-1:0] CMD_TMO_OFF = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_PD_ON   = 4'b1110;
  localparam logic [CMD_W-1:0] CMD_PD_OFF  = 4'b1111;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_MODE_A,
    RS_MODE_B,
    RS_MASKED,
    RS_RAW,
    RS_SCRATCH
  } rd_src_e;

  typedef struct packed {
    logic [NCH-1:0] mode_acc;
    logic [NCH-1:0] mode_wr;
    logic [NCH-1:0] cmd_wr;
    logic           mask_wr;
    logic           scr_wr;
    rd_src_e        rd_src;
  } dec_t;
endpackage

// File: rtl/sercfg_addr_dec.sv
module sercfg_addr_dec
  import sercfg_pkg::*;
(
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic hit_mode_a, hit_mode_b;

  assign hit_mode_a = (addr == ADR_MODE_A);
  assign hit_mode_b = (addr == ADR_MODE_B);

  always_comb begin
    dec.mode_acc = {hit_mode_b & (rd_en | wr_en), hit_mode_a & (rd_en | wr_en)};
    dec.mode_wr  = {hit_mode_b & wr_en, hit_mode_a & wr_en};
    dec.cmd_wr   = {wr_en & (addr == ADR_CMD_B), wr_en & (addr == ADR_CMD_A)};
    dec.mask_wr  = wr_en & (addr == ADR_STATMSK);
    dec.scr_wr   = wr_en & (addr == ADR_SCRATCH);
    dec.rd_src   = RS_NONE;
    if (rd_en) begin
      case (addr)
        ADR_MODE_A:  dec.rd_src = RS_MODE_A;
        ADR_MODE_B:  dec.rd_src = RS_MODE_B;
        ADR_CMD_A:   dec.rd_src = RS_MASKED;
        ADR_STATMSK: dec.rd_src = RS_RAW;
        ADR_SCRATCH: dec.rd_src = RS_SCRATCH;
        default:     dec.rd_src = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sercfg_chan.sv
module sercfg_chan
  import sercfg_pkg::*;
#(
  parameter bit HAS_PDOWN    = 1'b1,
  parameter bit HAS_EXT_BAUD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_acc,
  input  logic              mode_wr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_rd,
  output logic [DATA_W-1:0] mr0,
  output logic [DATA_W-1:0] mr1,
  output logic [DATA_W-1:0] mr2,
  output logic              rts_n,
  output logic              tmo_en,
  output logic              pdown,
  output logic              wdog_en,
  output logic [1:0]        rx_lvl,
  output logic [1:0]        tx_lvl
);
  localparam logic [DATA_W-1:0] MR0_KEEP = HAS_EXT_BAUD ? 8'hFF : 8'hF9;

  mode_ptr_e         ptr_q;
  logic [CMD_W-1:0]  cmd;

  assign cmd = wdata[DATA_W-1 -: CMD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= MP_MR1;
    end else if (cmd_wr && cmd == CMD_PTR_MR0) begin
      ptr_q <= MP_MR0;
    end else if (mode_acc) begin
      case (ptr_q)
        MP_MR0:  ptr_q <= MP_MR1;
        default: ptr_q <= MP_MR2;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr0 <= '0;
      mr1 <= '0;
      mr2 <= '0;
    end else if (mode_wr) begin
      case (ptr_q)
        MP_MR0:  mr0 <= wdata & MR0_KEEP;
        MP_MR1:  mr1 <= wdata;
        default: mr2 <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n  <= 1'b1;
      tmo_en <= 1'b0;
    end else if (cmd_wr) begin
      case (cmd)
        CMD_RTS_ON:  rts_n  <= 1'b0;
        CMD_RTS_OFF: rts_n  <= 1'b1;
        CMD_TMO_ON:  tmo_en <= 1'b1;
        CMD_TMO_OFF: tmo_en <= 1'b0;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_PDOWN) begin : g_pdown
      logic pd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pd_q <= 1'b0;
        end else if (cmd_wr && cmd == CMD_PD_ON) begin
          pd_q <= 1'b1;
        end else if (cmd_wr && cmd == CMD_PD_OFF) begin
          pd_q <= 1'b0;
        end
      end
      assign pdown = pd_q;
    end else begin : g_no_pdown
      assign pdown = 1'b0;
    end
  endgenerate

  always_comb begin
    case (ptr_q)
      MP_MR0:  mode_rd = mr0;
      MP_MR1:  mode_rd = mr1;
      default: mode_rd = mr2;
    endcase
  end

  assign wdog_en = mr0[7];
  assign tx_lvl  = mr0[5:4];
  assign rx_lvl  = {mr0[6], mr1[6]};
endmodule

// File: rtl/sercfg_irq.sv
module sercfg_irq
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] masked
);
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  assign masked = status & mask_q;
endmodule

// File: rtl/sercfg_front.sv
module sercfg_front
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] irq_status,
  output logic              rts_n_a,
  output logic              rts_n_b,
  output logic              tmo_en_a,
  output logic              tmo_en_b,
  output logic              pdown,
  output logic [DATA_W-1:0] mr0_a,
  output logic [DATA_W-1:0] mr1_a,
  output logic [DATA_W-1:0] mr2_a,
  output logic [DATA_W-1:0] mr0_b,
  output logic [DATA_W-1:0] mr1_b,
  output logic [DATA_W-1:0] mr2_b,
  output logic              wdog_en_a,
  output logic              wdog_en_b,
  output logic [1:0]        rx_lvl_a,
  output logic [1:0]        rx_lvl_b,
  output logic [1:0]        tx_lvl_a,
  output logic [1:0]        tx_lvl_b,
  output logic [1:0]        ext_baud_a
);
  dec_t              dec;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] scratch_q;

  logic [DATA_W-1:0] mode_rd_w [NCH];
  logic [DATA_W-1:0] mr0_w     [NCH];
  logic [DATA_W-1:0] mr1_w     [NCH];
  logic [DATA_W-1:0] mr2_w     [NCH];
  logic [1:0]        rx_w      [NCH];
  logic [1:0]        tx_w      [NCH];
  logic [NCH-1:0]    rts_w, tmo_w, pd_w, wdog_w;

  sercfg_addr_dec u_dec (
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .dec   (dec)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      sercfg_chan #(
        .HAS_PDOWN    (i == 0),
        .HAS_EXT_BAUD (i == 0)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_acc (dec.mode_acc[i]),
        .mode_wr  (dec.mode_wr[i]),
        .cmd_wr   (dec.cmd_wr[i]),
        .wdata    (wdata),
        .mode_rd  (mode_rd_w[i]),
        .mr0      (mr0_w[i]),
        .mr1      (mr1_w[i]),
        .mr2      (mr2_w[i]),
        .rts_n    (rts_w[i]),
        .tmo_en   (tmo_w[i]),
        .pdown    (pd_w[i]),
        .wdog_en  (wdog_w[i]),
        .rx_lvl   (rx_w[i]),
        .tx_lvl   (tx_w[i])
      );
    end
  endgenerate

  sercfg_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (dec.mask_wr),
    .wdata   (wdata),
    .status  (irq_status),
    .masked  (masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scratch_q <= '0;
    else if (dec.scr_wr) scratch_q <= wdata;
  end

  always_comb begin
    case (dec.rd_src)
      RS_MODE_A:  rdata = mode_rd_w[0];
      RS_MODE_B:  rdata = mode_rd_w[1];
      RS_MASKED:  rdata = masked;
      RS_RAW:     rdata = irq_status;
      RS_SCRATCH: rdata = scratch_q;
      default:    rdata = '0;
    endcase
  end

  assign rts_n_a    = rts_w[0];
  assign rts_n_b    = rts_w[1];
  assign tmo_en_a   = tmo_w[0];
  assign tmo_en_b   = tmo_w[1];
  assign pdown      = |pd_w;
  assign mr0_a      = mr0_w[0];
  assign mr1_a      = mr1_w[0];
  assign mr2_a      = mr2_w[0];
  assign mr0_b      = mr0_w[1];
  assign mr1_b      = mr1_w[1];
  assign mr2_b      = mr2_w[1];
  assign wdog_en_a  = wdog_w[0];
  assign wdog_en_b  = wdog_w[1];
  assign rx_lvl_a   = rx_w[0];
  assign rx_lvl_b   = rx_w[1];
  assign tx_lvl_a   = tx_w[0];
  assign tx_lvl_b   = tx_w[1];
  assign ext_baud_a = mr0_w[0][2:1];
endmodule

// File: rtl/sercfg_front_chk.sv
module sercfg_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] irq_status,
  input logic       rts_n_a,
  input logic       rts_n_b,
  input logic       tmo_en_a,
  input logic       pdown
);
  logic [7:0] mask_sh, scr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_sh <= '0;
      scr_sh  <= '0;
    end else begin
      if (wr_en && addr == 4'h5) mask_sh <= wdata;
      if (wr_en && addr == 4'hC) scr_sh  <= wdata;
    end
  end

  a_r4_rts_assert_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h2 && wdata[7:4] == 4'b1000) |=> !rts_n_a);

  a_r4_rts_negate_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hA && wdata[7:4] == 4'b1001) |=> rts_n_b);

  a_r7_rts_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 4'h2) |=> $stable(rts_n_a));

  a_r5_tmo_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h2 && wdata[7:4] == 4'b1010) |=> tmo_en_a);

  a_r5_tmo_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h2 && wdata[7:4] == 4'b1100) |=> !tmo_en_a);

  a_r6_pdown_b_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hA) |=> $stable(pdown));

  a_r8_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h2) |-> rdata == (irq_status & mask_sh));

  a_r9_scratch_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hC) |-> rdata == scr_sh);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
endmodule

bind sercfg_front sercfg_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .irq_status (irq_status),
  .rts_n_a    (rts_n_a),
  .rts_n_b    (rts_n_b),
  .tmo_en_a   (tmo_en_a),
  .pdown      (pdown)
);

// File: tb/sercfg_front_tb.sv
module sercfg_front_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_status = 8'hFF;
  logic       rts_n_a, rts_n_b, tmo_en_a, tmo_en_b, pdown, wdog_en_a, wdog_en_b;
  logic [7:0] mr0_a, mr1_a, mr2_a, mr0_b, mr1_b, mr2_b;
  logic [1:0] rx_lvl_a, rx_lvl_b, tx_lvl_a, tx_lvl_b, ext_baud_a;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_status(irq_status),
    .rts_n_a(rts_n_a), .rts_n_b(rts_n_b), .tmo_en_a(tmo_en_a), .tmo_en_b(tmo_en_b),
    .pdown(pdown), .mr0_a(mr0_a), .mr1_a(mr1_a), .mr2_a(mr2_a),
    .mr0_b(mr0_b), .mr1_b(mr1_b), .mr2_b(mr2_b),
    .wdog_en_a(wdog_en_a), .wdog_en_b(wdog_en_b),
    .rx_lvl_a(rx_lvl_a), .rx_lvl_b(rx_lvl_b), .tx_lvl_a(tx_lvl_a), .tx_lvl_b(tx_lvl_b),
    .ext_baud_a(ext_baud_a)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "rts_n_a", rts_n_a, 1);
    chk("R1", "rts_n_b", rts_n_b, 1);
    chk("R1", "tmo_en", {tmo_en_a, tmo_en_b}, 0);
    chk("R1", "pdown", pdown, 0);
    chk("R1", "mode regs", {mr0_a, mr1_a, mr2_a, mr0_b, mr1_b, mr2_b} == 48'h0, 1);
    bus_rd(4'hC, d);  chk("R1", "scratch", d, 8'h00);
    bus_rd(4'h2, d);  chk("R1", "masked with zero mask", d, 8'h00);
    bus_rd(4'h5, d);  chk("R8", "raw status", d, 8'hFF);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    bus_wr(4'h0, 8'h11); chk("R1", "first write lands in MR1", mr1_a, 8'h11);
    chk("R2", "MR0 untouched", mr0_a, 8'h00);
    bus_wr(4'h0, 8'h22); chk("R2", "second write lands in MR2", mr2_a, 8'h22);
    bus_wr(4'h0, 8'h33); chk("R2", "pointer stays on MR2", mr2_a, 8'h33);
    chk("R2", "MR1 kept", mr1_a, 8'h11);
    bus_rd(4'h0, d);     chk("R2", "read at end stop", d, 8'h33);
    bus_rd(4'h8, d);     chk("R2", "B read hits MR1", d, 8'h00);
    bus_wr(4'hC, 8'h77);
    bus_wr(4'h5, 8'h00);
    bus_wr(4'h8, 8'h44); chk("R13", "B write after other accesses hits MR2", mr2_b, 8'h44);
    chk("R13", "B MR1 untouched", mr1_b, 8'h00);
  endtask

  task automatic t_ptr_reset();
    logic [7:0] d;
    bus_wr(4'h2, 8'hB0);
    bus_wr(4'h0, 8'hF6); chk("R3", "A write after reset cmd hits MR0", mr0_a, 8'hF6);
    chk("R11", "wdog_en_a", wdog_en_a, 1);
    chk("R11", "tx_lvl_a", tx_lvl_a, 2'd3);
    chk("R11", "rx_lvl_a mixed", rx_lvl_a, 2'd2);
    chk("R10", "ext_baud_a", ext_baud_a, 2'd3);
    bus_wr(4'h0, 8'h40); chk("R3", "next write hits MR1", mr1_a, 8'h40);
    chk("R11", "rx_lvl_a both", rx_lvl_a, 2'd3);
    bus_rd(4'h0, d);     chk("R3", "read then at MR2", d, 8'h33);
    bus_wr(4'h0, 8'h5A); chk("R3", "A pointer held on MR2", mr2_a, 8'h5A);
    bus_wr(4'hA, 8'hB0);
    bus_wr(4'h8, 8'hFF); chk("R10", "B MR0 bits 2:1 dropped", mr0_b, 8'hF9);
    chk("R3", "A MR0 unaffected by B command", mr0_a, 8'hF6);
    chk("R11", "wdog_en_b", wdog_en_b, 1);
    chk("R11", "tx_lvl_b", tx_lvl_b, 2'd3);
    chk("R11", "rx_lvl_b", rx_lvl_b, 2'd2);
    bus_wr(4'hA, 8'hB0);
    bus_rd(4'h8, d);     chk("R10", "B MR0 readback", d, 8'hF9);
  endtask

  task automatic t_rts();
    bus_wr(4'h2, 8'h85); chk("R4", "A assert with low nibble set", rts_n_a, 0);
    chk("R4", "B unaffected", rts_n_b, 1);
    bus_wr(4'hA, 8'h80); chk("R4", "B assert", rts_n_b, 0);
    bus_wr(4'h2, 8'h9F); chk("R4", "A negate", rts_n_a, 1);
    bus_wr(4'hA, 8'hD0); chk("R7", "cmd D no effect", {rts_n_b, tmo_en_b}, 2'b00);
    bus_wr(4'hA, 8'h0F); chk("R7", "cmd 0 no effect", {rts_n_b, tmo_en_b}, 2'b00);
    chk("R7", "A untouched", {rts_n_a, tmo_en_a, pdown}, 3'b100);
  endtask

  task automatic t_timeout();
    bus_wr(4'hA, 8'hA0); chk("R5", "B time-out on", tmo_en_b, 1);
    chk("R5", "A time-out off", tmo_en_a, 0);
    bus_wr(4'h2, 8'hA7); chk("R5", "A time-out on", tmo_en_a, 1);
    bus_wr(4'hA, 8'hC3); chk("R5", "B time-out off", tmo_en_b, 0);
    chk("R5", "A still on", tmo_en_a, 1);
  endtask

  task automatic t_pdown();
    bus_wr(4'hA, 8'hE0); chk("R6", "B pdown-on ignored", pdown, 0);
    bus_wr(4'h2, 8'hE0); chk("R6", "A pdown on", pdown, 1);
    bus_wr(4'hA, 8'hF0); chk("R6", "B pdown-off ignored", pdown, 1);
    bus_wr(4'h2, 8'hF0); chk("R6", "A pdown off", pdown, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    irq_status = 8'h3C;
    bus_wr(4'h5, 8'h0F);
    bus_rd(4'h2, d); chk("R8", "masked after same-cycle change", d, 8'h0C);
    bus_rd(4'h5, d); chk("R8", "raw status, mask not readable", d, 8'h3C);
    irq_status = 8'hF1;
    bus_rd(4'h2, d); chk("R8", "masked follows status", d, 8'h01);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    bus_wr(4'hC, 8'hA5);
    bus_rd(4'hC, d); chk("R9", "scratch readback", d, 8'hA5);
    addr = 4'hC; #1;
    chk("R12", "rdata idle", rdata, 8'h00);
    bus_rd(4'h3, d); chk("R12", "unmapped read", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_ptr_reset();
    t_rts();
    t_timeout();
    t_pdown();
    t_irq();
    t_scratch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule